// File: doc/BRIEF.md
# Handshaking Parallel Port Controller

This block is a byte-wide parallel port placed between a CPU register bus and an external peripheral. Each pad can be an input or an output on its own. Two strobe lines coordinate transfers with the peripheral. `stra_i` is an asynchronous strobe coming in from the peripheral. `strb_o` is a strobe driven out to the peripheral. A single configuration register chooses how the two strobes behave, from three protocols:

- **Plain strobe.** Writing a dedicated output-only register gives a one-cycle pulse on `strb_o`.
- **Input handshake.** `strb_o` acts as a "ready to accept" signal.
- **Output handshake.** `strb_o` acts as a "data valid" signal, and the peripheral acknowledges it on `stra_i`.

In every mode, an active edge on `stra_i` captures the pads into a latch register and sets a sticky flag. When enabled, the flag drives a level interrupt.

The CPU side is a plain synchronous register bus with address, write data, write enable and read enable. Read data is combinational: it is valid while `rd_en_i` is high and depends on the current address. A read of the latch register takes effect at the clock edge that ends the read cycle. All control and status pins are plain levels; the block has no stream interface and applies no back-pressure. The peripheral must hold the pad values steady for at least four clock cycles after its strobe edge, because the edge is recognised only after synchronisation.

Top module: `hs_pport`

## Requirements
- R1: While reset is asserted, and right after it, `pad_oe_o` is 0 (all pads are inputs), the configuration register reads 0x00, `strb_o` is 0 (the inactive level), and `irq_o` is 0.
- R2: `pad_oe_o[i]` equals bit i of the direction register (address 2), where 1 means output. A read of address 0 returns, bit by bit, the pad input for input pins and the output latch for output pins.
- R3: `stra_i` is synchronised to the clock. Configuration bit 1 selects the active edge: 1 means rising, 0 means falling. An active edge copies `pad_di_i` into the latch register (address 1) and sets the flag (configuration bit 7), both visible after the third rising clock edge following the strobe edge. An inactive edge changes neither.
- R4: With configuration bit 4 = 0, a write to address 4 updates `sout_o` and makes `strb_o` active for exactly one cycle, starting after the write edge. Configuration bit 0 = 1 makes the active level low.
- R5: The flag is cleared by a read of address 1. A read that falls in the same cycle as a strobe event leaves the flag set. Writes to bit 7 of address 3 are ignored.
- R6: `irq_o` is high exactly when the flag is set and configuration bit 6 is 1.
- R7: With bit 4 = 1 and bit 3 = 0, `strb_o` becomes active after the configuration write if the flag is clear. It goes inactive on a strobe event and becomes active again on a read of address 1.
- R8: With bit 4 = 1 and bit 3 = 1, a write to address 0 makes `strb_o` active and clears the flag. A later strobe event makes `strb_o` inactive and sets the flag.
- R9: The address map is: 0 port data, 1 latch, 2 direction, 3 configuration, 4 strobe-out data. Address 1 ignores writes. Address 4 and unused addresses read 0. Configuration bits 5 and 2 are stored and read back, and have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| wr_en_i | input | 1 | Write strobe, one cycle per write |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| rdata_o | output | 8 | Read data, valid while rd_en_i is high |
| pad_di_i | input | 8 | Values sensed on the pads |
| pad_do_o | output | 8 | Values driven on output pads |
| pad_oe_o | output | 8 | Per-pad output enable |
| sout_o | output | 8 | Output-only strobe data register |
| stra_i | input | 1 | Asynchronous strobe from the peripheral |
| strb_o | output | 1 | Strobe to the peripheral |
| irq_o | output | 1 | Level interrupt |

## Verification
The delicate overlap is a CPU read of the latch register landing in the very cycle that a synchronised strobe event latches new data. The bench provokes it by driving `stra_i`, counting two clock edges, and then issuing the read so that it completes on the edge where the event is registered. It then judges that the read returned the old byte, the flag and interrupt remain set, and the latch now holds the new byte. The same cycle-counting approach shows that each protocol's strobe level changes on the edge that carries the event.

// File: rtl/hs_pport_pkg.sv
package hs_pport_pkg;
  localparam int PORT_W = 8;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PDAT  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LATCH = 3'd1;
  localparam logic [ADDR_W-1:0] A_DIR   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CFG   = 3'd3;
  localparam logic [ADDR_W-1:0] A_SOUT  = 3'd4;

  // configuration bit positions (bit 7 is the read-only flag)
  localparam int B_INV  = 0;
  localparam int B_EDGE = 1;
  localparam int B_PLS  = 2;
  localparam int B_OIN  = 3;
  localparam int B_HS   = 4;
  localparam int B_OD   = 5;
  localparam int B_IEN  = 6;

  typedef enum logic [1:0] {
    M_SIMPLE  = 2'd0,
    M_FULL_IN = 2'd1,
    M_FULL_OUT = 2'd2
  } hs_mode_e;
endpackage

// File: rtl/hs_pport_edge.sv
module hs_pport_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  input  logic rise_sel_i,
  output logic evt_o
);
  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q[0] <= 1'b0;
    else        sync_q[0] <= async_i;
  end

  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q[g] <= 1'b0;
      else        sync_q[g] <= sync_q[g-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= sync_q[STAGES-1];
  end

  assign evt_o = rise_sel_i ? (sync_q[STAGES-1] & ~last_q)
                            : (~sync_q[STAGES-1] & last_q);
endmodule

// File: rtl/hs_pport_hs.sv
module hs_pport_hs
  import hs_pport_pkg::*;
#(
  parameter int W = PORT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         evt_i,
  input  hs_mode_e     mode_i,
  input  hs_mode_e     new_mode_i,
  input  logic         wr_cfg_i,
  input  logic         wr_pdat_i,
  input  logic         wr_sout_i,
  input  logic         rd_latch_i,
  input  logic [W-1:0] pad_di_i,
  output logic [W-1:0] latch_o,
  output logic         flag_o,
  output logic         strb_act_o
);
  logic [W-1:0] latch_q;
  logic         flag_q;
  logic         act_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else if (evt_i) latch_q <= pad_di_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else if (evt_i) flag_q <= 1'b1;
    else if (rd_latch_i || (wr_pdat_i && mode_i == M_FULL_OUT)) flag_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else if (wr_cfg_i) act_q <= (new_mode_i == M_FULL_IN) && !flag_q;
    else begin
      unique case (mode_i)
        M_SIMPLE:  act_q <= wr_sout_i;
        M_FULL_IN: begin
          if (evt_i) act_q <= 1'b0;
          else if (rd_latch_i) act_q <= 1'b1;
        end
        M_FULL_OUT: begin
          if (wr_pdat_i) act_q <= 1'b1;
          else if (evt_i) act_q <= 1'b0;
        end
        default: act_q <= 1'b0;
      endcase
    end
  end

  assign latch_o    = latch_q;
  assign flag_o     = flag_q;
  assign strb_act_o = act_q;
endmodule

// File: rtl/hs_pport.sv
module hs_pport
  import hs_pport_pkg::*;
#(
  parameter int W           = PORT_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [W-1:0]      wdata_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  output logic [W-1:0]      rdata_o,
  input  logic [W-1:0]      pad_di_i,
  output logic [W-1:0]      pad_do_o,
  output logic [W-1:0]      pad_oe_o,
  output logic [W-1:0]      sout_o,
  input  logic              stra_i,
  output logic              strb_o,
  output logic              irq_o
);
  localparam int CFG_W = 7;

  logic [W-1:0]     dout_q, dir_q, sout_q, latch_w;
  logic [CFG_W-1:0] cfg_q;
  logic             wr_pdat, wr_dir, wr_cfg, wr_sout, rd_latch;
  logic             stra_evt, staf_q, strb_act;
  hs_mode_e         mode, new_mode;

  assign wr_pdat  = wr_en_i && addr_i == A_PDAT;
  assign wr_dir   = wr_en_i && addr_i == A_DIR;
  assign wr_cfg   = wr_en_i && addr_i == A_CFG;
  assign wr_sout  = wr_en_i && addr_i == A_SOUT;
  assign rd_latch = rd_en_i && addr_i == A_LATCH;

  function automatic hs_mode_e mode_of(input logic hs, input logic oin);
    if (!hs) return M_SIMPLE;
    return oin ? M_FULL_OUT : M_FULL_IN;
  endfunction

  assign mode     = mode_of(cfg_q[B_HS], cfg_q[B_OIN]);
  assign new_mode = mode_of(wdata_i[B_HS], wdata_i[B_OIN]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= '0;
      dir_q  <= '0;
      sout_q <= '0;
      cfg_q  <= '0;
    end else begin
      if (wr_pdat) dout_q <= wdata_i;
      if (wr_dir)  dir_q  <= wdata_i;
      if (wr_sout) sout_q <= wdata_i;
      if (wr_cfg)  cfg_q  <= wdata_i[CFG_W-1:0];
    end
  end

  hs_pport_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .async_i    (stra_i),
    .rise_sel_i (cfg_q[B_EDGE]),
    .evt_o      (stra_evt)
  );

  hs_pport_hs #(.W(W)) u_hs (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_i      (stra_evt),
    .mode_i     (mode),
    .new_mode_i (new_mode),
    .wr_cfg_i   (wr_cfg),
    .wr_pdat_i  (wr_pdat),
    .wr_sout_i  (wr_sout),
    .rd_latch_i (rd_latch),
    .pad_di_i   (pad_di_i),
    .latch_o    (latch_w),
    .flag_o     (staf_q),
    .strb_act_o (strb_act)
  );

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      unique case (addr_i)
        A_PDAT:  rdata_o = (pad_di_i & ~dir_q) | (dout_q & dir_q);
        A_LATCH: rdata_o = latch_w;
        A_DIR:   rdata_o = dir_q;
        A_CFG:   rdata_o = {staf_q, cfg_q};
        default: rdata_o = '0;
      endcase
    end
  end

  assign pad_do_o = dout_q;
  assign pad_oe_o = dir_q;
  assign sout_o   = sout_q;
  assign strb_o   = strb_act ^ cfg_q[B_INV];
  assign irq_o    = staf_q & cfg_q[B_IEN];
endmodule

// File: rtl/hs_pport_chk.sv
module hs_pport_chk
  import hs_pport_pkg::*;
#(
  parameter int W = PORT_W
) (
  input logic         clk,
  input logic         rst_n,
  input logic         evt,
  input logic         staf,
  input logic [6:0]   cfg,
  input logic         wr_pdat,
  input logic         wr_sout,
  input logic         wr_cfg,
  input logic         rd_latch,
  input logic [W-1:0] pad_oe,
  input logic         strb,
  input logic         irq
);
  logic strb_on;
  assign strb_on = strb ^ cfg[B_INV];

  always @(posedge clk) begin
    if (!rst_n) a_r1_reset_idle: assert (pad_oe == '0 && !irq && !strb);
  end

  a_r3_single_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !wr_cfg) |=> !evt);

  a_r4_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg[B_HS] && strb_on && !wr_sout && !wr_cfg) |=> !strb_on);

  a_r5_flag_survives_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_latch && evt) |=> staf);

  a_r6_irq_follows_event: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && cfg[B_IEN] && !wr_cfg) |=> irq);

  a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[B_HS] && !cfg[B_OIN] && evt && !wr_cfg) |=> !strb_on);

  a_r8_ack_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg[B_HS] && cfg[B_OIN] && evt && !wr_cfg && !wr_pdat) |=> (!strb_on && staf));
endmodule

bind hs_pport hs_pport_chk #(.W(W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .evt      (stra_evt),
  .staf     (staf_q),
  .cfg      (cfg_q),
  .wr_pdat  (wr_pdat),
  .wr_sout  (wr_sout),
  .wr_cfg   (wr_cfg),
  .rd_latch (rd_latch),
  .pad_oe   (pad_oe_o),
  .strb     (strb_o),
  .irq      (irq_o)
);

// File: tb/hs_pport_tb.sv
module hs_pport_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic       wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rdata, pad_di = '0, pad_do, pad_oe, sout;
  logic       stra = 1'b0;
  logic       strb, irq;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  hs_pport u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr), .wdata_i(wdata),
    .wr_en_i(wr_en), .rd_en_i(rd_en), .rdata_o(rdata),
    .pad_di_i(pad_di), .pad_do_o(pad_do), .pad_oe_o(pad_oe), .sout_o(sout),
    .stra_i(stra), .strb_o(strb), .irq_o(irq)
  );

  // {dir, out latch, pad input, expected port read}
  localparam logic [31:0] VEC [4] = '{
    32'h00_FF_3C_3C, 32'hFF_A5_00_A5, 32'h0F_C3_5A_53, 32'hF0_81_7E_8E
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    #1 d = rdata;
    @(posedge clk);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic strobe(input logic lvl);
    @(negedge clk);
    stra = lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    logic [7:0] d;
    #1;
    chk("R1 oe in reset", pad_oe, 8'h00);
    chk("R1 strb in reset", {7'd0, strb}, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    chk("R1 irq", {7'd0, irq}, 8'h00);
    rd(3'd3, d); chk("R1 cfg", d, 8'h00);

    // R2 table walk
    for (int i = 0; i < 4; i++) begin
      wr(3'd2, VEC[i][31:24]);
      wr(3'd0, VEC[i][23:16]);
      pad_di = VEC[i][15:8];
      chk("R2 oe", pad_oe, VEC[i][31:24]);
      rd(3'd0, d); chk("R2 port read", d, VEC[i][7:0]);
    end
    wr(3'd2, 8'h00);

    // R9 map and R5 read-only flag bit
    rd(3'd4, d); chk("R9 sout reads 0", d, 8'h00);
    rd(3'd7, d); chk("R9 unused reads 0", d, 8'h00);
    wr(3'd1, 8'hAA);
    rd(3'd1, d); chk("R9 latch ignores write", d, 8'h00);
    wr(3'd3, 8'hA4);
    rd(3'd3, d); chk("R5 R9 flag bit ignored, spare bits kept", d, 8'h24);

    // R3 rising edge select
    wr(3'd3, 8'h02);
    pad_di = 8'h5A;
    strobe(1'b1);
    rd(3'd3, d); chk("R3 flag after rise", d, 8'h82);
    chk("R6 no irq when disabled", {7'd0, irq}, 8'h00);
    rd(3'd1, d); chk("R3 latched", d, 8'h5A);
    rd(3'd3, d); chk("R5 flag cleared", d, 8'h02);
    pad_di = 8'h11;
    strobe(1'b0);
    rd(3'd3, d); chk("R3 falling edge ignored", d, 8'h02);
    rd(3'd1, d); chk("R3 latch kept", d, 8'h5A);

    // R3 falling edge select with interrupt
    wr(3'd3, 8'h40);
    pad_di = 8'h33;
    strobe(1'b1);
    chk("R6 no irq on inactive edge", {7'd0, irq}, 8'h00);
    strobe(1'b0);
    chk("R6 irq raised", {7'd0, irq}, 8'h01);
    rd(3'd1, d); chk("R3 falling latch", d, 8'h33);
    chk("R6 irq cleared", {7'd0, irq}, 8'h00);

    // R5 read colliding with event
    wr(3'd3, 8'h42);
    pad_di = 8'h77;
    @(negedge clk) stra = 1'b1;
    repeat (2) @(posedge clk);
    rd(3'd1, d); chk("R5 read returns old byte", d, 8'h33);
    rd(3'd3, d); chk("R5 flag kept on collision", d, 8'hC2);
    chk("R5 irq kept", {7'd0, irq}, 8'h01);
    rd(3'd1, d); chk("R5 new byte latched", d, 8'h77);

    // R4 simple strobe
    wr(3'd3, 8'h00);
    chk("R4 idle", {7'd0, strb}, 8'h00);
    wr(3'd4, 8'h9C);
    chk("R4 sout", sout, 8'h9C);
    chk("R4 pulse active", {7'd0, strb}, 8'h01);
    @(negedge clk); chk("R4 pulse ends", {7'd0, strb}, 8'h00);
    wr(3'd3, 8'h01);
    chk("R4 inverted idle", {7'd0, strb}, 8'h01);
    wr(3'd4, 8'h3E);
    chk("R4 inverted pulse", {7'd0, strb}, 8'h00);
    @(negedge clk); chk("R4 inverted end", {7'd0, strb}, 8'h01);

    // R7 full-input handshake (stra is high, falling edge active)
    wr(3'd3, 8'h10);
    chk("R7 ready after config", {7'd0, strb}, 8'h01);
    pad_di = 8'h44;
    strobe(1'b0);
    chk("R7 ready drops", {7'd0, strb}, 8'h00);
    rd(3'd3, d); chk("R7 flag", d, 8'h90);
    rd(3'd1, d); chk("R7 data", d, 8'h44);
    chk("R7 ready again", {7'd0, strb}, 8'h01);

    // R8 full-output handshake
    wr(3'd2, 8'hFF);
    wr(3'd3, 8'h18);
    chk("R8 idle after config", {7'd0, strb}, 8'h00);
    wr(3'd0, 8'hE1);
    chk("R8 valid asserted", {7'd0, strb}, 8'h01);
    chk("R8 pads", pad_do, 8'hE1);
    strobe(1'b1);
    chk("R8 inactive edge no ack", {7'd0, strb}, 8'h01);
    strobe(1'b0);
    chk("R8 ack drops strobe", {7'd0, strb}, 8'h00);
    rd(3'd3, d); chk("R8 flag set", d, 8'h98);
    wr(3'd0, 8'h1E);
    rd(3'd3, d); chk("R8 flag cleared by write", d, 8'h18);
    chk("R8 valid again", {7'd0, strb}, 8'h01);

    done = 1;
    finish_run();
  end
endmodule